// File: doc/BRIEF.md
# Radio Transceiver State Controller

This block is the control state machine of a low-power packet radio. It moves the transceiver between five operating states: powered down, synthesizer running, receive listening, receive busy and transmit busy. A host drives it with state-change commands, and transmission can also be triggered from a dedicated trigger pin. The analog front end reports its progress through status strobes. These cover the regulator settling, synthesizer lock, sync header detection, a valid PHY header, the final frame byte with its CRC verdict, and the end of a transmission.

In return the controller enables the voltage regulator, the frequency synthesizer and the receiver. It also reports a numeric state code and emits single-cycle interrupt pulses for synthesizer lock, receive start and receive end. Leaving power-down is sequenced: the regulator comes up first, and the synthesizer is enabled only once the regulator is settled. The receiver may be switched on before the synthesizer has locked. Frame detection is suppressed until lock, so no frame can start on an unsettled carrier. Commands that arrive while a frame is being received or sent are remembered and carried out once the busy state ends.

Top module: `trx_state_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the state code is 0, all enables are low, all interrupt pulses are low and the CRC-valid flag is low.
- R2: Command code 2 (power up) in the off state moves the state code to 1 and raises the regulator enable on the next clock. The synthesizer enable rises only on the clock after a cycle in which both the regulator enable and the regulator-settled input are high.
- R3: The first lock strobe seen while the synthesizer is enabled and not yet locked produces a lock interrupt lasting exactly one cycle. Further lock strobes while locked produce none.
- R4: Command code 3 (listen) in state 1 moves to state 2 and raises the receiver enable on the next clock, whether or not the synthesizer has locked.
- R5: In state 2 a sync-header strobe is ignored while the synthesizer is unlocked.
- R6: In state 2 with the synthesizer locked, a sync-header strobe moves the controller to state 3 on the next clock without any command.
- R7: In state 3 a valid-PHY-header strobe produces a receive-start interrupt lasting exactly one cycle.
- R8: In state 3 a last-byte strobe returns the controller to state 2 on the next clock. On that same clock the receive-end interrupt pulses for one cycle and the CRC-valid output takes the value of the CRC input. The CRC-valid output holds that value until the next frame end.
- R9: State 2 persists indefinitely while no command is given.
- R10: From state 1, either command code 4 (transmit) or a rising edge on the trigger pin moves the controller to state 4. A transmit-done strobe in state 4 returns it to state 1.
- R11: Transmit commands and trigger-pin edges in any state other than 1 are ignored, and a trigger pin held high does not retrigger.
- R12: Command code 1 (off) from state 1 or 2 moves the controller to state 0, and on the same clock the regulator, synthesizer and receiver enables all drop.
- R13: A command accepted while in state 3 or 4 is held and applied on the clock after the controller leaves the busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_code_i | input | 3 | Command: 1 off, 2 power up, 3 listen, 4 transmit; other codes ignored |
| tx_trig_i | input | 1 | Trigger pin for transmit; rising edge starts a transmission |
| vreg_ready_i | input | 1 | Regulator settled |
| pll_lock_i | input | 1 | Synthesizer lock strobe |
| shr_det_i | input | 1 | Valid sync header detected |
| phr_ok_i | input | 1 | Valid PHY header received |
| last_byte_i | input | 1 | Last frame byte received |
| crc_ok_i | input | 1 | CRC verdict, sampled with last_byte_i |
| tx_done_i | input | 1 | Transmission finished |
| vreg_en_o | output | 1 | Regulator enable |
| synth_en_o | output | 1 | Synthesizer enable |
| rx_en_o | output | 1 | Receiver enable |
| state_o | output | 3 | State code: 0 off, 1 synthesizer on, 2 listen, 3 receive busy, 4 transmit busy |
| irq_pll_lock_o | output | 1 | Lock interrupt pulse |
| irq_rx_start_o | output | 1 | Receive-start interrupt pulse |
| irq_rx_end_o | output | 1 | Receive-end interrupt pulse |
| crc_valid_o | output | 1 | CRC result of the most recent frame |

## Verification
Every state register drives the state code directly, so a wrong transition is visible at state_o on the very clock it happens. A lost or spurious lock flag shows up a cycle later, either as a sync-header strobe that is wrongly accepted or refused in listen, or as a lock interrupt that repeats or never comes. A dropped pending command shows as a state code that stays at 2 or 1 on the clock after a busy state ends instead of moving on. Power-sequencing faults show as synth_en_o rising with, or ahead of, the regulator-settled cycle.

// File: rtl/trx_ctrl_pkg.sv
package trx_ctrl_pkg;

    localparam int ST_W  = 3;
    localparam int CMD_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_OFF    = 3'd0,
        ST_SYNTH  = 3'd1,
        ST_LISTEN = 3'd2,
        ST_RXBUSY = 3'd3,
        ST_TXBUSY = 3'd4
    } trx_state_e;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP    = 3'd0,
        CMD_OFF    = 3'd1,
        CMD_SYNTH  = 3'd2,
        CMD_LISTEN = 3'd3,
        CMD_TX     = 3'd4
    } trx_cmd_e;

    typedef struct packed {
        logic     valid;
        trx_cmd_e code;
    } trx_req_t;

    typedef struct packed {
        logic shr;
        logic phr;
        logic last;
        logic crc_ok;
        logic tx_done;
    } fe_evt_t;

    function automatic logic is_busy(trx_state_e s);
        return (s == ST_RXBUSY) || (s == ST_TXBUSY);
    endfunction

    function automatic logic is_rx(trx_state_e s);
        return (s == ST_LISTEN) || (s == ST_RXBUSY);
    endfunction

    // Unknown codes become an invalid request so no later stage sees them.
    function automatic trx_req_t decode_req(logic vld, logic [CMD_W-1:0] raw);
        trx_req_t r;
        r.valid = vld && (raw >= 3'd1) && (raw <= 3'd4);
        r.code  = r.valid ? trx_cmd_e'(raw) : CMD_NOP;
        return r;
    endfunction

endpackage

// File: rtl/trx_cmd_hold.sv
module trx_cmd_hold
    import trx_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     busy_i,
    input  trx_req_t req_i,
    output trx_req_t req_o
);
    trx_req_t pend_q;

    // Latest command during a busy state wins; slot empties once idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (busy_i) begin
            if (req_i.valid) pend_q <= req_i;
        end else begin
            pend_q <= '0;
        end
    end

    always_comb begin
        if (busy_i)           req_o = '0;
        else if (req_i.valid) req_o = req_i;
        else                  req_o = pend_q;
    end
endmodule

// File: rtl/trx_trig_edge.sv
module trx_trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_i;
    end

    assign rise_o = pin_i & ~pin_q;
endmodule

// File: rtl/trx_power_seq.sv
module trx_power_seq (
    input  logic clk,
    input  logic rst,
    input  logic power_req_i,
    input  logic vreg_ready_i,
    input  logic pll_lock_i,
    output logic vreg_en_o,
    output logic synth_en_o,
    output logic locked_o,
    output logic irq_lock_o
);
    logic vreg_q, synth_q, lock_q, irq_q;
    logic synth_d, lock_d;

    // Synthesizer only after regulator has been on and reported settled.
    assign synth_d = power_req_i && (synth_q || (vreg_q && vreg_ready_i));
    assign lock_d  = synth_d && (lock_q || (synth_q && pll_lock_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            vreg_q  <= 1'b0;
            synth_q <= 1'b0;
            lock_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            vreg_q  <= power_req_i;
            synth_q <= synth_d;
            lock_q  <= lock_d;
            irq_q   <= lock_d && !lock_q;
        end
    end

    assign vreg_en_o  = vreg_q;
    assign synth_en_o = synth_q;
    assign locked_o   = lock_q;
    assign irq_lock_o = irq_q;
endmodule

// File: rtl/trx_state_fsm.sv
module trx_state_fsm
    import trx_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trx_req_t   req_i,
    input  logic       tx_rise_i,
    input  fe_evt_t    evt_i,
    input  logic       locked_i,
    output trx_state_e state_q_o,
    output trx_state_e state_d_o,
    output logic       irq_start_o,
    output logic       irq_end_o,
    output logic       crc_valid_o
);
    trx_state_e st_q, st_d;
    logic start_q, end_q, crc_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (req_i.valid && req_i.code == CMD_SYNTH) st_d = ST_SYNTH;
            end
            ST_SYNTH: begin
                if ((req_i.valid && req_i.code == CMD_TX) || tx_rise_i)
                    st_d = ST_TXBUSY;
                else if (req_i.valid && req_i.code == CMD_LISTEN)
                    st_d = ST_LISTEN;
                else if (req_i.valid && req_i.code == CMD_OFF)
                    st_d = ST_OFF;
            end
            ST_LISTEN: begin
                if (req_i.valid && req_i.code == CMD_OFF)
                    st_d = ST_OFF;
                else if (req_i.valid && req_i.code == CMD_SYNTH)
                    st_d = ST_SYNTH;
                else if (evt_i.shr && locked_i)
                    st_d = ST_RXBUSY;
            end
            ST_RXBUSY: begin
                if (evt_i.last) st_d = ST_LISTEN;
            end
            ST_TXBUSY: begin
                if (evt_i.tx_done) st_d = ST_SYNTH;
            end
            default: st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_OFF;
            start_q <= 1'b0;
            end_q   <= 1'b0;
            crc_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            start_q <= (st_q == ST_RXBUSY) && evt_i.phr;
            end_q   <= (st_q == ST_RXBUSY) && evt_i.last;
            if ((st_q == ST_RXBUSY) && evt_i.last) crc_q <= evt_i.crc_ok;
        end
    end

    assign state_q_o   = st_q;
    assign state_d_o   = st_d;
    assign irq_start_o = start_q;
    assign irq_end_o   = end_q;
    assign crc_valid_o = crc_q;
endmodule

// File: rtl/trx_state_ctrl.sv
module trx_state_ctrl
    import trx_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid_i,
    input  logic [CMD_W-1:0] cmd_code_i,
    input  logic             tx_trig_i,
    input  logic             vreg_ready_i,
    input  logic             pll_lock_i,
    input  logic             shr_det_i,
    input  logic             phr_ok_i,
    input  logic             last_byte_i,
    input  logic             crc_ok_i,
    input  logic             tx_done_i,
    output logic             vreg_en_o,
    output logic             synth_en_o,
    output logic             rx_en_o,
    output logic [ST_W-1:0]  state_o,
    output logic             irq_pll_lock_o,
    output logic             irq_rx_start_o,
    output logic             irq_rx_end_o,
    output logic             crc_valid_o
);
    trx_req_t   req_raw, req_eff;
    trx_state_e st_q, st_d;
    fe_evt_t    evt;
    logic       tx_rise, locked;

    assign req_raw = decode_req(cmd_valid_i, cmd_code_i);
    assign evt     = '{shr: shr_det_i, phr: phr_ok_i, last: last_byte_i,
                       crc_ok: crc_ok_i, tx_done: tx_done_i};

    trx_cmd_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .busy_i (is_busy(st_q)),
        .req_i  (req_raw),
        .req_o  (req_eff)
    );

    trx_trig_edge u_trig (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (tx_trig_i),
        .rise_o (tx_rise)
    );

    trx_state_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_eff),
        .tx_rise_i   (tx_rise),
        .evt_i       (evt),
        .locked_i    (locked),
        .state_q_o   (st_q),
        .state_d_o   (st_d),
        .irq_start_o (irq_rx_start_o),
        .irq_end_o   (irq_rx_end_o),
        .crc_valid_o (crc_valid_o)
    );

    trx_power_seq u_pwr (
        .clk          (clk),
        .rst          (rst),
        .power_req_i  (st_d != ST_OFF),
        .vreg_ready_i (vreg_ready_i),
        .pll_lock_i   (pll_lock_i),
        .vreg_en_o    (vreg_en_o),
        .synth_en_o   (synth_en_o),
        .locked_o     (locked),
        .irq_lock_o   (irq_pll_lock_o)
    );

    assign state_o = st_q;
    assign rx_en_o = is_rx(st_q);
endmodule

// File: rtl/trx_ctrl_chk.sv
module trx_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       vreg_ready_i,
    input logic       shr_det_i,
    input logic       vreg_en_o,
    input logic       synth_en_o,
    input logic       rx_en_o,
    input logic [2:0] state_o,
    input logic       irq_pll_lock_o,
    input logic       irq_rx_start_o,
    input logic       irq_rx_end_o
);
    AST_SYNTH_AFTER_VREG: assert property (@(posedge clk) disable iff (rst)
        $rose(synth_en_o) |-> ($past(vreg_ready_i) && $past(vreg_en_o))); // R2
    AST_LOCK_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_pll_lock_o |=> !irq_pll_lock_o); // R3
    AST_RXBUSY_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3 && $past(state_o) != 3'd3) |-> ($past(state_o) == 3'd2 && $past(shr_det_i))); // R6
    AST_RXSTART_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        irq_rx_start_o |-> ($past(state_o) == 3'd3)); // R7
    AST_RXEND_RETURN: assert property (@(posedge clk) disable iff (rst)
        irq_rx_end_o |-> (state_o == 3'd2 && $past(state_o) == 3'd3)); // R8
    AST_TX_FROM_SYNTH: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 && $past(state_o) != 3'd4) |-> ($past(state_o) == 3'd1)); // R11
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0) |-> (!vreg_en_o && !synth_en_o && !rx_en_o)); // R12
endmodule

bind trx_state_ctrl trx_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .vreg_ready_i   (vreg_ready_i),
    .shr_det_i      (shr_det_i),
    .vreg_en_o      (vreg_en_o),
    .synth_en_o     (synth_en_o),
    .rx_en_o        (rx_en_o),
    .state_o        (state_o),
    .irq_pll_lock_o (irq_pll_lock_o),
    .irq_rx_start_o (irq_rx_start_o),
    .irq_rx_end_o   (irq_rx_end_o)
);

// File: tb/tb_trx_state_ctrl.sv
module tb_trx_state_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid_i = 1'b0;
    logic [2:0] cmd_code_i = 3'd0;
    logic       tx_trig_i = 1'b0, vreg_ready_i = 1'b0, pll_lock_i = 1'b0;
    logic       shr_det_i = 1'b0, phr_ok_i = 1'b0, last_byte_i = 1'b0;
    logic       crc_ok_i = 1'b0, tx_done_i = 1'b0;
    logic       vreg_en_o, synth_en_o, rx_en_o;
    logic [2:0] state_o;
    logic       irq_pll_lock_o, irq_rx_start_o, irq_rx_end_o, crc_valid_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk; // 50 MHz

    trx_state_ctrl dut (.*);

    // Input bundle: {valid, code[2:0], trig, vreg, lock, shr, phr, last, crc, done}
    // Expected:     {state[2:0], vreg_en, synth_en, rx_en, irq_lock, irq_start, irq_end, crc}
    localparam int NV = 27;
    localparam logic [25:0] VEC [NV] = '{
        {4'd1,  12'b0_000_0_0_0_0_0_0_0_0, 10'b000_0_0_0_0_0_0_0}, // R1 idle after reset
        {4'd2,  12'b1_010_0_0_0_0_0_0_0_0, 10'b001_1_0_0_0_0_0_0}, // R2 power up
        {4'd2,  12'b0_000_0_0_0_0_0_0_0_0, 10'b001_1_0_0_0_0_0_0}, // R2 waiting for regulator
        {4'd2,  12'b0_000_0_1_0_0_0_0_0_0, 10'b001_1_1_0_0_0_0_0}, // R2 synth follows settle
        {4'd4,  12'b1_011_0_1_0_0_0_0_0_0, 10'b010_1_1_1_0_0_0_0}, // R4 listen before lock
        {4'd5,  12'b0_000_0_1_0_1_0_0_0_0, 10'b010_1_1_1_0_0_0_0}, // R5 sync ignored unlocked
        {4'd3,  12'b0_000_0_1_1_0_0_0_0_0, 10'b010_1_1_1_1_0_0_0}, // R3 lock pulse
        {4'd3,  12'b0_000_0_1_1_0_0_0_0_0, 10'b010_1_1_1_0_0_0_0}, // R3 no repeat
        {4'd6,  12'b0_000_0_1_0_1_0_0_0_0, 10'b011_1_1_1_0_0_0_0}, // R6 sync accepted
        {4'd7,  12'b0_000_0_1_0_0_1_0_0_0, 10'b011_1_1_1_0_1_0_0}, // R7 rx start pulse
        {4'd7,  12'b0_000_0_1_0_0_0_0_0_0, 10'b011_1_1_1_0_0_0_0}, // R7 pulse ends
        {4'd8,  12'b0_000_0_1_0_0_0_1_1_0, 10'b010_1_1_1_0_0_1_1}, // R8 frame end, crc good
        {4'd8,  12'b0_000_0_1_0_0_0_0_0_0, 10'b010_1_1_1_0_0_0_1}, // R8 crc held
        {4'd9,  12'b0_000_0_1_0_0_0_0_0_0, 10'b010_1_1_1_0_0_0_1}, // R9 stays listening
        {4'd11, 12'b1_100_0_1_0_0_0_0_0_0, 10'b010_1_1_1_0_0_0_1}, // R11 tx cmd in listen
        {4'd11, 12'b0_000_1_1_0_0_0_0_0_0, 10'b010_1_1_1_0_0_0_1}, // R11 trig edge in listen
        {4'd10, 12'b1_010_0_1_0_0_0_0_0_0, 10'b001_1_1_0_0_0_0_1}, // R10 back to synth on
        {4'd10, 12'b1_100_0_1_0_0_0_0_0_0, 10'b100_1_1_0_0_0_0_1}, // R10 tx by command
        {4'd13, 12'b1_011_0_1_0_0_0_0_0_0, 10'b100_1_1_0_0_0_0_1}, // R13 listen held while tx
        {4'd10, 12'b0_000_0_1_0_0_0_0_0_1, 10'b001_1_1_0_0_0_0_1}, // R10 tx done
        {4'd13, 12'b0_000_0_1_0_0_0_0_0_0, 10'b010_1_1_1_0_0_0_1}, // R13 pending applied
        {4'd10, 12'b1_010_0_1_0_0_0_0_0_0, 10'b001_1_1_0_0_0_0_1}, // R10 synth on
        {4'd10, 12'b0_000_1_1_0_0_0_0_0_0, 10'b100_1_1_0_0_0_0_1}, // R10 tx by trig edge
        {4'd10, 12'b0_000_1_1_0_0_0_0_0_1, 10'b001_1_1_0_0_0_0_1}, // R10 done, trig held
        {4'd11, 12'b0_000_1_1_0_0_0_0_0_0, 10'b001_1_1_0_0_0_0_1}, // R11 held trig no retrigger
        {4'd12, 12'b1_001_0_0_0_0_0_0_0_0, 10'b000_0_0_0_0_0_0_1}, // R12 off from synth on
        {4'd12, 12'b0_000_0_1_0_0_0_0_0_0, 10'b000_0_0_0_0_0_0_1}  // R12 stays powered down
    };

    task automatic drive(input logic [11:0] in);
        {cmd_valid_i, cmd_code_i, tx_trig_i, vreg_ready_i, pll_lock_i,
         shr_det_i, phr_ok_i, last_byte_i, crc_ok_i, tx_done_i} = in;
        @(negedge clk);
    endtask

    task automatic expect_out(input int req, input logic [9:0] exp, input string what);
        logic [9:0] got;
        got = {state_o, vreg_en_o, synth_en_o, rx_en_o,
               irq_pll_lock_o, irq_rx_start_o, irq_rx_end_o, crc_valid_o};
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out(1, 10'b000_0_0_0_0_0_0_0, "outputs in reset"); // R1
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][21:10]);
            expect_out(int'(VEC[i][25:22]), VEC[i][9:0], $sformatf("vector %0d", i));
        end

        // R2: regulator already settled when power-up arrives
        drive(12'b1_010_0_1_0_0_0_0_0_0);
        expect_out(2, 10'b001_1_0_0_0_0_0_1, "synth must wait one cycle");
        drive(12'b0_000_0_1_0_0_0_0_0_0);
        expect_out(2, 10'b001_1_1_0_0_0_0_1, "synth enabled");
        drive(12'b1_011_0_1_0_0_0_0_0_0);
        drive(12'b0_000_0_1_1_0_0_0_0_0);
        expect_out(3, 10'b010_1_1_1_1_0_0_1, "lock pulse after relock");
        drive(12'b0_000_0_1_0_1_0_0_0_0);
        expect_out(6, 10'b011_1_1_1_0_0_0_1, "enter receive busy");
        // R13: off during a frame is deferred
        drive(12'b1_001_0_1_0_0_0_0_0_0);
        expect_out(13, 10'b011_1_1_1_0_0_0_1, "off held during frame");
        drive(12'b0_000_0_1_0_0_0_1_0_0);
        expect_out(8, 10'b010_1_1_1_0_0_1_0, "frame end with bad crc");
        drive(12'b0_000_0_1_0_0_0_0_0_0);
        expect_out(13, 10'b000_0_0_0_0_0_0_0, "deferred off applied");

        // R9: long stay in listen, then R12 off from listen
        drive(12'b1_010_0_1_0_0_0_0_0_0);
        drive(12'b0_000_0_1_0_0_0_0_0_0);
        drive(12'b1_011_0_1_1_0_0_0_0_0);
        begin
            logic stayed;
            stayed = 1'b1;
            for (int k = 0; k < 40; k++) begin
                drive(12'b0_000_0_1_0_0_0_0_0_0);
                if (state_o !== 3'd2) stayed = 1'b0;
            end
            n_cmp++;
            if (!stayed) begin
                n_bad++;
                $display("FAIL R9 listen persistence: got left state expected 2 throughout");
            end
        end
        drive(12'b1_001_0_1_0_0_0_0_0_0);
        expect_out(12, 10'b000_0_0_0_0_0_0_0, "off from listen");

        // R11: trigger edge in the off state is ignored, held pin does not fire later
        drive(12'b0_000_1_1_0_0_0_0_0_0);
        expect_out(11, 10'b000_0_0_0_0_0_0_0, "trig edge while off");
        drive(12'b1_010_1_1_0_0_0_0_0_0);
        expect_out(11, 10'b001_1_0_0_0_0_0_0, "power up with trig held");
        drive(12'b0_000_1_1_0_0_0_0_0_0);
        expect_out(11, 10'b001_1_1_0_0_0_0_0, "held trig does not start tx");

        // R1: reset in the middle of operation
        rst = 1'b1;
        drive(12'b0_000_0_1_0_0_0_0_0_0);
        expect_out(1, 10'b000_0_0_0_0_0_0_0, "mid-run reset");
        rst = 1'b0;
        drive(12'b0_000_0_1_0_0_0_0_0_0);
        expect_out(1, 10'b000_0_0_0_0_0_0_0, "first cycle after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule